// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-port synchronous static RAM with a registered read path. It is meant to serve as the data store of a secondary cache. Every address, write-data and control input is sampled on the rising clock edge. The exceptions are output enable, sleep and the burst-order select, which act combinationally. A burst begins when either of two start strobes is seen while the chip enable is high. One strobe is meant for the processor side and the other for the cache controller. The strobe loads the external address. After that, a 2-bit wrap counter supplies the next three word addresses whenever the advance input is high, in either linear or interleaved order.

Writes are decoded per byte lane. A write-enable with a byte-enable mask writes only the selected lanes. A global write writes the whole word. A read goes through a registered array access and then an output register, so the data appears two rising edges after the edge that started the access. Output enable and sleep gate the valid flag and the data. While sleep is high the array and the burst state are frozen.

Top module: `burst_sram`

## Requirements
- R1: A rising edge with `strb_cpu` or `strb_ctl` high and `chip_en` high loads `addr` as the burst base and accesses `addr` at that same edge; either strobe behaves identically.
- R2: During an active burst with no strobe, an edge with `adv` high steps the 2-bit counter by one and accesses the new address; with `adv` low the same address is accessed again.
- R3: With `ileave` low the two low address bits of access k (k = 0..3) are (base low bits + k) modulo 4, e.g. base 1 gives 1,2,3,0.
- R4: With `ileave` high the two low address bits of access k are base low bits XOR k, e.g. base 1 gives 1,0,3,2.
- R5: Address bits above bit 1 stay equal to the loaded base for the whole burst; the counter never carries into them.
- R6: An access with `wr_en` high and `glob_wr` low writes only lane i (`wdata` bits 8i+7..8i) for each i where `byte_en[i]` is high; other lanes keep their contents.
- R7: An access with `glob_wr` high writes all four lanes regardless of `wr_en` and `byte_en`.
- R8: An access with `wr_en` and `glob_wr` low is a read; its word appears on `rdata` with `rvalid` high after the second rising edge following the access edge.
- R9: An edge with a strobe high and `chip_en` low ends the burst, performs no access, and leaves `rvalid` low two edges later; later edges do no access until the next start.
- R10: While `oe` is low or `sleep` is high, `rvalid` is low and `rdata` is zero, with no clock edge needed.
- R11: Edges with `sleep` high perform no write, no read and no change of the burst counter, base or active state.
- R12: After reset `rvalid` is low, `rdata` is zero and no burst is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address loaded at burst start |
| strb_cpu | input | 1 | Processor-side burst start strobe |
| strb_ctl | input | 1 | Controller-side burst start strobe |
| chip_en | input | 1 | Chip enable sampled with a strobe; low deselects |
| adv | input | 1 | Burst advance |
| wr_en | input | 1 | Write enable used with byte enables |
| glob_wr | input | 1 | Write all lanes |
| byte_en | input | DATA_W/LANE_W | Per-lane write enables |
| wdata | input | DATA_W | Write data |
| oe | input | 1 | Output enable, combinational |
| sleep | input | 1 | Freeze and mask outputs, combinational |
| ileave | input | 1 | Burst order: 0 linear, 1 interleaved |
| rdata | output | DATA_W | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
A counter that steps wrongly or carries into the upper bits makes the wrong word come out. Because every test word holds a distinct value, this shows as a data mismatch exactly two edges after the faulty access. A byte-lane decode error stays hidden in the array until that word is read back, so every masked write is followed at once by a read of the same word. A lost sleep or deselect gate shows up in one of two ways. `rvalid` goes high two edges after an edge that should have done nothing, or a word that should have been left alone changes, which the final read sweep brings out.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

   localparam int unsigned CNT_W = 2;

   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } burst_order_e;

   // low address bits of the current beat within a 4-word block
   function automatic logic [CNT_W-1:0] beat_low(input logic [CNT_W-1:0] base_lo,
                                                  input logic [CNT_W-1:0] beat,
                                                  input burst_order_e     order);
      logic [CNT_W-1:0] r;
      if (order == ORD_INTERLEAVE) r = base_lo ^ beat;
      else                         r = CNT_W'(base_lo + beat);
      return r;
   endfunction

endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_sram_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep,
   input  logic              ileave,
   input  logic              start_a,
   input  logic              start_b,
   input  logic              chip_en,
   input  logic              adv,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic              acc_valid,
   output logic [ADDR_W-1:0] acc_addr
);

   localparam int unsigned HI_W = ADDR_W - CNT_W;

   if (ADDR_W <= CNT_W) begin : g_bad_addr_w
      $error("burst_addr_gen: ADDR_W must exceed the burst counter width");
   end

   logic [ADDR_W-1:0] base_q, base_n;
   logic [CNT_W-1:0]  cnt_q, cnt_n;
   logic              active_q, active_n;
   logic              start, load, desel;
   burst_order_e      order;

   assign start = start_a | start_b;
   assign load  = start & chip_en;
   assign desel = start & ~chip_en;
   assign order = burst_order_e'(ileave);

   always_comb begin
      base_n   = base_q;
      cnt_n    = cnt_q;
      active_n = active_q;
      if (load) begin
         base_n   = ext_addr;
         cnt_n    = '0;
         active_n = 1'b1;
      end else if (desel) begin
         active_n = 1'b0;
      end else if (active_q && adv) begin
         cnt_n = CNT_W'(cnt_q + 1'b1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (!sleep) begin
         base_q   <= base_n;
         cnt_q    <= cnt_n;
         active_q <= active_n;
      end
   end

   assign acc_valid = ~sleep & (load | (active_q & ~desel));
   assign acc_addr  = {base_n[ADDR_W-1 -: HI_W], beat_low(base_n[CNT_W-1:0], cnt_n, order)};

   AST_BASE_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
                       (sleep || !load) |=> $stable(base_q));                          // R5
   AST_CNT_HOLD:    assert property (@(posedge clk) disable iff (!rst_n)
                       (!sleep && !load && !adv) |=> $stable(cnt_q));                  // R2
   AST_CNT_STEP:    assert property (@(posedge clk) disable iff (!rst_n)
                       (!sleep && !start && active_q && adv)
                       |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));                      // R2
   AST_LOAD_ZERO:   assert property (@(posedge clk) disable iff (!rst_n)
                       (!sleep && load) |=> (active_q && cnt_q == '0));                // R1
   AST_DESEL_END:   assert property (@(posedge clk) disable iff (!rst_n)
                       (!sleep && desel) |=> !active_q);                               // R9
   AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
                       sleep |=> ($stable(active_q) && $stable(cnt_q)));               // R11

endmodule

// File: rtl/byte_write_dec.sv
module byte_write_dec #(
   parameter int unsigned NUM_LANES = 4
) (
   input  logic                 acc_valid,
   input  logic                 wr_en,
   input  logic                 glob_wr,
   input  logic [NUM_LANES-1:0] byte_en,
   output logic [NUM_LANES-1:0] lane_we,
   output logic                 rd_req
);

   if (NUM_LANES < 1) begin : g_bad_lanes
      $error("byte_write_dec: NUM_LANES must be at least one");
   end

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      assign lane_we[i] = acc_valid & (glob_wr | (wr_en & byte_en[i]));
   end

   assign rd_req = acc_valid & ~glob_wr & ~wr_en;

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned LANE_W    = 8,
   parameter int unsigned NUM_LANES = 4
) (
   input  logic                        clk,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [NUM_LANES-1:0]        lane_we,
   input  logic                        rd_en,
   input  logic [NUM_LANES*LANE_W-1:0] wdata,
   output logic [NUM_LANES*LANE_W-1:0] rd_data
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   if (DEPTH * NUM_LANES > 8192) begin : g_too_big
      $error("sram_lane_array: array exceeds model size limit");
   end

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] q;

      always_ff @(posedge clk) begin
         if (lane_we[i]) mem[addr] <= wdata[i*LANE_W +: LANE_W];
         if (rd_en)      q         <= mem[addr];
      end

      assign rd_data[i*LANE_W +: LANE_W] = q;
   end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
   import burst_sram_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LANE_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     strb_cpu,
   input  logic                     strb_ctl,
   input  logic                     chip_en,
   input  logic                     adv,
   input  logic                     wr_en,
   input  logic                     glob_wr,
   input  logic [DATA_W/LANE_W-1:0] byte_en,
   input  logic [DATA_W-1:0]        wdata,
   input  logic                     oe,
   input  logic                     sleep,
   input  logic                     ileave,
   output logic [DATA_W-1:0]        rdata,
   output logic                     rvalid
);

   localparam int unsigned NUM_LANES = DATA_W / LANE_W;

   if (DATA_W % LANE_W != 0) begin : g_bad_lane_w
      $error("burst_sram: DATA_W must be a multiple of LANE_W");
   end

   logic                 acc_valid;
   logic [ADDR_W-1:0]    acc_addr;
   logic [NUM_LANES-1:0] lane_we;
   logic                 rd_req;
   logic [DATA_W-1:0]    arr_q;
   logic                 s1_v;
   logic                 out_v;
   logic [DATA_W-1:0]    out_d;

   burst_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep     (sleep),
      .ileave    (ileave),
      .start_a   (strb_cpu),
      .start_b   (strb_ctl),
      .chip_en   (chip_en),
      .adv       (adv),
      .ext_addr  (addr),
      .acc_valid (acc_valid),
      .acc_addr  (acc_addr)
   );

   byte_write_dec #(.NUM_LANES(NUM_LANES)) u_wdec (
      .acc_valid (acc_valid),
      .wr_en     (wr_en),
      .glob_wr   (glob_wr),
      .byte_en   (byte_en),
      .lane_we   (lane_we),
      .rd_req    (rd_req)
   );

   sram_lane_array #(
      .ADDR_W    (ADDR_W),
      .LANE_W    (LANE_W),
      .NUM_LANES (NUM_LANES)
   ) u_array (
      .clk     (clk),
      .addr    (acc_addr),
      .lane_we (lane_we),
      .rd_en   (rd_req),
      .wdata   (wdata),
      .rd_data (arr_q)
   );

   // array output register stage followed by the output register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v  <= 1'b0;
         out_v <= 1'b0;
         out_d <= '0;
      end else begin
         s1_v  <= rd_req;
         out_v <= s1_v;
         out_d <= arr_q;
      end
   end

   assign rvalid = out_v & oe & ~sleep;
   assign rdata  = rvalid ? out_d : '0;

   AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
                        rd_req |-> ##2 out_v);                                        // R8
   AST_NO_READ_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
                        !s1_v |=> !out_v);                                            // R9
   AST_GLOBAL_ALL:   assert property (@(posedge clk) disable iff (!rst_n)
                        (acc_valid && glob_wr) |-> (&lane_we));                       // R7
   AST_SLEEP_QUIET:  assert property (@(posedge clk) disable iff (!rst_n)
                        sleep |-> (lane_we == '0 && !rd_req));                        // R11
   AST_WRITE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
                        (|lane_we) |-> !rd_req);                                      // R6

endmodule

// File: tb/burst_sram_tb.sv
`timescale 1ns/1ps
module burst_sram_tb_top;

   localparam int AW = 5;
   localparam int DW = 32;
   localparam int NL = 4;
   localparam int WORDS = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          strb_cpu = 1'b0, strb_ctl = 1'b0, chip_en = 1'b1, adv = 1'b0;
   logic          wr_en = 1'b0, glob_wr = 1'b0;
   logic [NL-1:0] byte_en = '0;
   logic [DW-1:0] wdata = '0;
   logic          oe = 1'b1, sleep = 1'b0, ileave = 1'b0;
   logic [DW-1:0] rdata;
   logic          rvalid;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   burst_sram #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .strb_cpu(strb_cpu), .strb_ctl(strb_ctl),
      .chip_en(chip_en), .adv(adv), .wr_en(wr_en), .glob_wr(glob_wr), .byte_en(byte_en),
      .wdata(wdata), .oe(oe), .sleep(sleep), .ileave(ileave), .rdata(rdata), .rvalid(rvalid)
   );

   // bench reference state, built from the requirements
   logic [DW-1:0] m_mem [WORDS];
   logic [AW-1:0] m_base = '0;
   logic [1:0]    m_cnt = '0;
   logic          m_act = 1'b0;
   logic          m_s1v = 1'b0, m_ov = 1'b0;
   logic [DW-1:0] m_s1d = '0, m_od = '0;

   task automatic check(input string req, input logic [DW-1:0] act_d, input logic act_v,
                        input logic [DW-1:0] exp_d, input logic exp_v);
      checks++;
      if (act_d !== exp_d || act_v !== exp_v) begin
         errors++;
         $display("FAIL %s: rdata=%h rvalid=%b expected rdata=%h rvalid=%b",
                  req, act_d, act_v, exp_d, exp_v);
      end
   endtask

   task automatic cyc(input string req);
      logic          acc, wr;
      logic [1:0]    lo;
      logic [AW-1:0] a;
      logic          ev;
      @(posedge clk);
      acc = 1'b0;
      wr  = 1'b0;
      a   = '0;
      if (!sleep) begin
         if ((strb_cpu || strb_ctl) && !chip_en) m_act = 1'b0;
         else if (strb_cpu || strb_ctl) begin
            m_base = addr; m_cnt = 2'd0; m_act = 1'b1; acc = 1'b1;
         end else if (m_act) begin
            if (adv) m_cnt = m_cnt + 2'd1;
            acc = 1'b1;
         end
      end
      if (acc) begin
         lo = ileave ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
         a  = {m_base[AW-1:2], lo};
         wr = glob_wr | wr_en;
      end
      m_ov = m_s1v;
      m_od = m_s1d;
      m_s1v = acc & ~wr;
      if (acc && !wr) m_s1d = m_mem[a];
      if (acc) begin
         for (int i = 0; i < NL; i++)
            if (glob_wr || (wr_en && byte_en[i])) m_mem[a][i*8 +: 8] = wdata[i*8 +: 8];
      end
      #1;
      ev = m_ov & oe & ~sleep;
      check(req, rdata, rvalid, ev ? m_od : '0, ev);
   endtask

   task automatic quiet();
      strb_cpu = 0; strb_ctl = 0; adv = 0; wr_en = 0; glob_wr = 0; byte_en = '0;
   endtask

   // deselect then two empty edges to drain the read pipeline
   task automatic flush(input string req);
      quiet(); strb_cpu = 1; chip_en = 0;
      cyc(req);
      strb_cpu = 0; chip_en = 1;
      cyc(req); cyc(req);
   endtask

   task automatic burst(input logic [AW-1:0] a0, input logic ctl, input logic il,
                        input logic gw, input logic [DW-1:0] seed, input string req);
      ileave = il;
      for (int k = 0; k < 4; k++) begin
         quiet();
         if (k == 0) begin
            addr = a0; strb_cpu = ~ctl; strb_ctl = ctl;
         end else adv = 1;
         glob_wr = gw;
         wdata = seed + 32'(k) * 32'h01030507;
         cyc(req);
      end
      flush(req);
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < WORDS; i++) m_mem[i] = '0;
      repeat (3) @(posedge clk);
      #1;
      check("R12", rdata, rvalid, '0, 1'b0);
      rst_n = 1;
      cyc("R12"); cyc("R12");

      // fill every word with distinct values through global-write bursts (R7, R3)
      for (int b = 0; b < WORDS / 4; b++)
         burst(AW'(b * 4 + (b % 4)), b[0], 1'b0, 1'b1, 32'hC0DE0000 + 32'(b) * 32'h00110000, "R7");

      // every start offset, both orders, both strobes (R1, R3, R4, R5, R8)
      for (int b = 0; b < WORDS / 4; b++)
         for (int o = 0; o < 4; o++) begin
            burst(AW'(b * 4 + o), o[1], 1'b0, 1'b0, '0, "R3");
            burst(AW'(b * 4 + o), o[0], 1'b1, 1'b0, '0, "R4");
         end

      // global write ignores byte enables and wr_en (R7)
      quiet(); addr = 5'd6; strb_ctl = 1; glob_wr = 1; byte_en = 4'b0000; wdata = 32'h7E57_0006;
      cyc("R7");
      flush("R7");
      burst(5'd4, 1'b0, 1'b0, 1'b0, '0, "R7");

      // every byte mask: write then read back same word (R6)
      for (int m = 0; m < 16; m++) begin
         quiet(); addr = 5'd13; strb_cpu = 1; wr_en = 1; byte_en = NL'(m);
         wdata = 32'h1000_0001 * 32'(m + 1) ^ 32'hFFFF_FFFF;
         cyc("R6");
         quiet(); addr = 5'd13; strb_cpu = 1;
         cyc("R6");
         flush("R6");
      end

      // advance held low repeats the address (R2)
      ileave = 0;
      quiet(); addr = 5'd18; strb_cpu = 1; cyc("R2");
      quiet(); adv = 1; cyc("R2");
      quiet(); cyc("R2"); cyc("R2");
      adv = 1; cyc("R2"); cyc("R2"); cyc("R2");
      flush("R2");

      // deselect mid-burst, further advances do nothing (R9)
      quiet(); addr = 5'd21; strb_ctl = 1; cyc("R9");
      quiet(); adv = 1; cyc("R9");
      quiet(); strb_ctl = 1; chip_en = 0; cyc("R9");
      quiet(); chip_en = 1; adv = 1; wr_en = 1; byte_en = 4'hF; wdata = 32'hDEAD_BEEF;
      cyc("R9"); cyc("R9"); cyc("R9");
      flush("R9");

      // output enable and sleep mask the output (R10)
      quiet(); addr = 5'd24; strb_cpu = 1; cyc("R10");
      quiet(); adv = 1; cyc("R10"); cyc("R10");
      oe = 0; #1; check("R10", rdata, rvalid, '0, 1'b0);
      cyc("R10");
      oe = 1; cyc("R10");
      flush("R10");

      // sleep freezes state and blocks writes (R11)
      quiet(); addr = 5'd9; strb_cpu = 1; cyc("R11");
      quiet(); adv = 1; cyc("R11");
      sleep = 1; glob_wr = 1; wdata = 32'hBAD0_BAD0;
      #1; check("R10", rdata, rvalid, '0, 1'b0);
      cyc("R11"); cyc("R11");
      quiet(); strb_ctl = 1; addr = 5'd30; cyc("R11");
      sleep = 0; quiet(); adv = 1;
      cyc("R11"); cyc("R11"); cyc("R11");
      flush("R11");

      // final read sweep of all words (R5, R8)
      for (int b = 0; b < WORDS / 4; b++)
         burst(AW'(b * 4), b[0], 1'b0, 1'b0, '0, "R8");

      // reset in mid-burst clears output and burst (R12)
      quiet(); addr = 5'd3; strb_cpu = 1; cyc("R12");
      quiet(); adv = 1; cyc("R12");
      rst_n = 0; #1;
      check("R12", rdata, rvalid, '0, 1'b0);
      m_act = 0; m_s1v = 0; m_ov = 0; m_od = '0; m_s1d = '0; m_cnt = '0; m_base = '0;
      @(posedge clk); #1;
      rst_n = 1;
      cyc("R12"); cyc("R12"); cyc("R12");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule